// File: doc/BRIEF.md
# First-Level Translation Table Walker

This block turns a 32-bit virtual address into a result taken from a single first-level translation table in memory. A requester presents a virtual address and a flag that marks the access as an instruction fetch or a data access. The block takes the table base from its base input when it accepts the request. It then builds the word address of the matching descriptor and fetches that word over a plain valid/ready read port.

The returned descriptor is decoded from its two low bits. A section entry splices a physical address from the descriptor and the virtual address. Bit 18 picks the splice: a 1MB section or a 16MB supersection. A level-2 pointer entry hands back the aligned level-2 table base and the domain. A fault entry, or the reserved encoding, returns an abort, classed by the access type.

The walker serves one request at a time. It steps through idle, read issue, wait, and a one-cycle respond state. The second-level walk, permission checks, memory attributes and any translation caching belong to logic outside this block.

Top module: `l1_xlate_walker`

## Requirements
- R1: Out of reset, and whenever no walk is in progress, `reqReady` is 1 while `memRdValid` and `rspValid` are 0. `reqReady` is 0 from the cycle after a request is accepted until the cycle after the response.
- R2: The descriptor read address is table base bits [31:14], then virtual address bits [31:20], then two zero bits. The base and the virtual address are the values sampled at acceptance. Base bits [13:0], and any later change of the base input, have no effect.
- R3: `memRdValid` rises in the cycle after acceptance. It stays high, with `memRdAddr` unchanged, until the cycle in which `memRdReady` is high, and falls after that cycle.
- R4: `rspValid` is high for exactly one cycle, the cycle right after the clock edge at which `memRspValid` is seen while waiting. Exactly one response occurs per accepted request.
- R5: For descriptor bits [1:0] = 10 with bit 18 clear, the result has `rspKind` = 00 and `rspSuper` = 0. `rspAddr` is descriptor bits [31:20] joined with virtual address bits [19:0].
- R6: For descriptor bits [1:0] = 10 with bit 18 set, the result has `rspKind` = 00 and `rspSuper` = 1. `rspAddr` is descriptor bits [31:24] joined with virtual address bits [23:0].
- R7: For descriptor bits [1:0] = 01, the result has `rspKind` = 01. `rspAddr` is descriptor bits [31:10] with ten zero bits below them, and `rspDomain` is descriptor bits [8:5].
- R8: For descriptor bits [1:0] = 00 or 11, the result is an abort. `rspKind` is 10 for an instruction fetch (`reqIsFetch` = 1) and 11 for a data access, and `rspAddr` is the virtual address.
- R9: `rspAttr` equals descriptor bits [19:2] in every response.
- R10: `memRspValid` has no effect unless a walk is waiting for its descriptor. `reqValid` has no effect while a walk is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblBase | input | 32 | First-level table base; bits [31:14] used |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and accepting |
| reqVa | input | 32 | Virtual address to translate |
| reqIsFetch | input | 1 | 1 = instruction fetch, 0 = data access |
| memRdValid | output | 1 | Descriptor read request |
| memRdReady | input | 1 | Memory accepts the read |
| memRdAddr | output | 32 | Descriptor word address |
| memRspValid | input | 1 | Descriptor data present |
| memRspData | input | 32 | Descriptor word |
| rspValid | output | 1 | Result valid, one cycle |
| rspKind | output | 2 | 00 physical, 01 level-2 pointer, 10 prefetch abort, 11 data abort |
| rspAddr | output | 32 | Physical address, level-2 base, or faulting virtual address |
| rspDomain | output | 4 | Domain field of the descriptor |
| rspSuper | output | 1 | Physical result came from a supersection |
| rspAttr | output | 18 | Descriptor bits [19:2], passed through |

## Verification
The read request is due one cycle after the accepting edge. The response is due exactly one cycle after the edge that carries the descriptor in. The driver records that due cycle when it presents the descriptor, and the monitor checks that `rspValid` appears in that cycle and drops in the next. Stalls on both memory handshakes vary from zero to several cycles. Stray response strobes and requests are injected while the walker is busy, and the base input is changed after acceptance. The read address is checked at the handshake edge, and each result field is compared with a queued expectation.

// File: rtl/l1w_pkg.sv
`timescale 1ns/1ps
package l1w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2,
    ST_RESP = 2'd3
  } walkState_e;

  // result classes as seen on rspKind
  localparam logic [1:0] KIND_PHYS = 2'b00;
  localparam logic [1:0] KIND_L2   = 2'b01;
  localparam logic [1:0] KIND_PABT = 2'b10;
  localparam logic [1:0] KIND_DABT = 2'b11;

  // descriptor type codes in bits [1:0]
  localparam logic [1:0] DT_FAULT = 2'b00;
  localparam logic [1:0] DT_L2    = 2'b01;
  localparam logic [1:0] DT_SECT  = 2'b10;
  localparam logic [1:0] DT_RSVD  = 2'b11;

  typedef struct packed {
    logic takeReq;   // latch request fields and base
    logic takeDesc;  // latch returned descriptor
  } walkStrobe_t;
endpackage

// File: rtl/l1w_ctrl.sv
`timescale 1ns/1ps
module l1w_ctrl
  import l1w_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdReady,
  input  logic        memRspValid,
  output logic        reqReady,
  output logic        memRdValid,
  output logic        rspValid,
  output walkStrobe_t strobe
);
  walkState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (reqValid)    stateNext = ST_READ;
      ST_READ: if (memRdReady)  stateNext = ST_WAIT;
      ST_WAIT: if (memRspValid) stateNext = ST_RESP;
      ST_RESP:                  stateNext = ST_IDLE;
      default:                  stateNext = ST_IDLE;
    endcase
  end

  assign reqReady        = (state == ST_IDLE);
  assign memRdValid      = (state == ST_READ);
  assign rspValid        = (state == ST_RESP);
  assign strobe.takeReq  = reqReady && reqValid;
  assign strobe.takeDesc = (state == ST_WAIT) && memRspValid;

  AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memRdValid && !rspValid)); // R1
  AST_RD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> memRdValid); // R3
  AST_RD_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> (memRdValid && !reqReady)); // R3
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> (!rspValid && reqReady)); // R4
  AST_RSP_AFTER_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(memRspValid)); // R4
endmodule

// File: rtl/l1w_dpath.sv
`timescale 1ns/1ps
module l1w_dpath
  import l1w_pkg::*;
#(
  parameter int VA_W        = 32,
  parameter int IDX_W       = 12,
  parameter int TBL_ALIGN   = 14,
  parameter int SUPER_BIT   = 18,
  parameter int SUPER_ALIGN = 24,
  parameter int L2_ALIGN    = 10,
  parameter int DOM_LSB     = 5,
  parameter int DOM_W       = 4,
  localparam int SECT_OFF   = VA_W - IDX_W,
  localparam int ATTR_W     = SECT_OFF - 2,
  localparam int BASE_W     = VA_W - TBL_ALIGN
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic [VA_W-1:0]   tblBase,
  input  logic [VA_W-1:0]   reqVa,
  input  logic              reqIsFetch,
  input  logic [VA_W-1:0]   memRspData,
  output logic [VA_W-1:0]   memRdAddr,
  output logic [1:0]        rspKind,
  output logic [VA_W-1:0]   rspAddr,
  output logic [DOM_W-1:0]  rspDomain,
  output logic              rspSuper,
  output logic [ATTR_W-1:0] rspAttr
);
  logic [BASE_W-1:0] baseHi;
  logic [VA_W-1:0]   vaReg;
  logic [VA_W-1:0]   descReg;
  logic              fetchReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseHi   <= '0;
      vaReg    <= '0;
      fetchReg <= 1'b0;
    end else if (strobe.takeReq) begin
      baseHi   <= tblBase[VA_W-1:TBL_ALIGN];
      vaReg    <= reqVa;
      fetchReg <= reqIsFetch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                descReg <= '0;
    else if (strobe.takeDesc) descReg <= memRspData;
  end

  // descriptor word address: base high part, table index, word offset
  assign memRdAddr = {baseHi, vaReg[VA_W-1:SECT_OFF], 2'b00};

  logic [1:0]      descType;
  logic            isSuper;
  logic [VA_W-1:0] sectAddr, superAddr, l2Addr;

  assign descType  = descReg[1:0];
  assign isSuper   = (descType == DT_SECT) && descReg[SUPER_BIT];
  assign sectAddr  = {descReg[VA_W-1:SECT_OFF], vaReg[SECT_OFF-1:0]};
  assign superAddr = {descReg[VA_W-1:SUPER_ALIGN], vaReg[SUPER_ALIGN-1:0]};
  assign l2Addr    = {descReg[VA_W-1:L2_ALIGN], {L2_ALIGN{1'b0}}};

  always_comb begin
    rspSuper = 1'b0;
    unique case (descType)
      DT_SECT: begin
        rspKind  = KIND_PHYS;
        rspAddr  = isSuper ? superAddr : sectAddr;
        rspSuper = isSuper;
      end
      DT_L2: begin
        rspKind = KIND_L2;
        rspAddr = l2Addr;
      end
      default: begin  // DT_FAULT and DT_RSVD both abort
        rspKind = fetchReg ? KIND_PABT : KIND_DABT;
        rspAddr = vaReg;
      end
    endcase
  end

  assign rspDomain = descReg[DOM_LSB +: DOM_W];
  assign rspAttr   = descReg[SECT_OFF-1:2];

  AST_SECT_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    (rspKind == KIND_PHYS && !rspSuper) |-> (rspAddr[SECT_OFF-1:0] == vaReg[SECT_OFF-1:0])); // R5
  AST_SUPER_OFFSET: assert property (@(posedge clk) disable iff (!rstN)
    rspSuper |-> (rspKind == KIND_PHYS && rspAddr[SUPER_ALIGN-1:0] == vaReg[SUPER_ALIGN-1:0])); // R6
  AST_L2_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    (rspKind == KIND_L2) |-> (rspAddr[L2_ALIGN-1:0] == '0)); // R7
  AST_ABORT_VA: assert property (@(posedge clk) disable iff (!rstN)
    rspKind[1] |-> (rspAddr == vaReg && !rspSuper)); // R8
endmodule

// File: rtl/l1_xlate_walker.sv
`timescale 1ns/1ps
module l1_xlate_walker
  import l1w_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] tblBase,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVa,
  input  logic        reqIsFetch,
  output logic        memRdValid,
  input  logic        memRdReady,
  output logic [31:0] memRdAddr,
  input  logic        memRspValid,
  input  logic [31:0] memRspData,
  output logic        rspValid,
  output logic [1:0]  rspKind,
  output logic [31:0] rspAddr,
  output logic [3:0]  rspDomain,
  output logic        rspSuper,
  output logic [17:0] rspAttr
);
  walkStrobe_t strobe;

  l1w_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memRdReady  (memRdReady),
    .memRspValid (memRspValid),
    .reqReady    (reqReady),
    .memRdValid  (memRdValid),
    .rspValid    (rspValid),
    .strobe      (strobe)
  );

  l1w_dpath uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .tblBase    (tblBase),
    .reqVa      (reqVa),
    .reqIsFetch (reqIsFetch),
    .memRspData (memRspData),
    .memRdAddr  (memRdAddr),
    .rspKind    (rspKind),
    .rspAddr    (rspAddr),
    .rspDomain  (rspDomain),
    .rspSuper   (rspSuper),
    .rspAttr    (rspAttr)
  );

  AST_RDADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdReady) |=> $stable(memRdAddr)); // R3
  AST_RDADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> (memRdAddr[1:0] == 2'b00)); // R2
endmodule

// File: tb/tb_l1_xlate_walker.sv
`timescale 1ns/1ps
module tb_l1_xlate_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] tblBase = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVa = '0;
  logic        reqIsFetch = 1'b0;
  logic        memRdValid;
  logic        memRdReady = 1'b0;
  logic [31:0] memRdAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid;
  logic [1:0]  rspKind;
  logic [31:0] rspAddr;
  logic [3:0]  rspDomain;
  logic        rspSuper;
  logic [17:0] rspAttr;

  always #2.5 clk = ~clk;

  l1_xlate_walker dut (.*);

  typedef struct {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [3:0]  dom;
    logic        sup;
    logic [17:0] attr;
    bit          chkDom;
  } expRsp_t;

  expRsp_t expQ[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int rspDue = -1;
  bit prevRsp = 1'b0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic expRsp_t model(input logic [31:0] d, input logic [31:0] va, input bit fetch);
    expRsp_t e;
    e.attr = d[19:2];
    e.dom = d[8:5];
    e.sup = 1'b0;
    e.chkDom = 1'b0;
    case (d[1:0])
      2'b10: begin
        e.kind = 2'b00;
        if (d[18]) begin e.sup = 1'b1; e.addr = {d[31:24], va[23:0]}; end
        else e.addr = {d[31:20], va[19:0]};
      end
      2'b01: begin e.kind = 2'b01; e.addr = {d[31:10], 10'b0}; e.chkDom = 1'b1; end
      default: begin e.kind = fetch ? 2'b10 : 2'b11; e.addr = va; end
    endcase
    return e;
  endfunction

  // monitor: pops expectations as results appear
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rspValid) begin
        check(cyc == rspDue, "R4 response cycle", cyc, rspDue);
        check(!prevRsp, "R4 single-cycle pulse", {31'b0, prevRsp}, 32'd0);
        if (expQ.size() == 0) begin
          check(1'b0, "R4 unexpected response", 32'd1, 32'd0);
        end else begin
          expRsp_t e;
          e = expQ.pop_front();
          check(rspKind == e.kind, "R5/R6/R7/R8 kind", rspKind, e.kind);
          check(rspAddr == e.addr, "R5/R6/R7/R8 addr", rspAddr, e.addr);
          check(rspSuper == e.sup, "R6 super flag", rspSuper, e.sup);
          check(rspAttr == e.attr, "R9 attr", rspAttr, e.attr);
          if (e.chkDom) check(rspDomain == e.dom, "R7 domain", rspDomain, e.dom);
        end
      end
      prevRsp = rspValid;
    end
  end

  task automatic walk(input logic [31:0] base, input logic [31:0] va, input bit fetch,
                      input logic [31:0] desc, input int rdStall, input int rspGap);
    logic [31:0] expRd;
    expRd = {base[31:14], va[31:20], 2'b00};
    @(negedge clk);
    check(reqReady, "R1 ready when idle", reqReady, 1);
    tblBase = base; reqVa = va; reqIsFetch = fetch; reqValid = 1'b1;
    expQ.push_back(model(desc, va, fetch));
    @(negedge clk);
    // R2: base and request change after acceptance must not matter
    tblBase = ~base; reqVa = ~va; reqIsFetch = ~fetch;
    check(memRdValid, "R3 read issued after accept", memRdValid, 1);
    check(!reqReady, "R1 busy after accept", reqReady, 0);
    // R10: keep presenting a request and a stray response while busy
    memRspValid = 1'b1; memRspData = 32'h0000_0003;
    for (int i = 0; i < rdStall; i++) begin
      @(negedge clk);
      check(memRdValid, "R3 read held", memRdValid, 1);
      check(memRdAddr == expRd, "R3 read addr held", memRdAddr, expRd);
      check(!reqReady, "R10 busy ignores request", reqReady, 0);
    end
    memRspValid = 1'b0;
    check(memRdAddr == expRd, "R2 descriptor address", memRdAddr, expRd);
    memRdReady = 1'b1;
    @(negedge clk);
    memRdReady = 1'b0;
    check(!memRdValid, "R3 read dropped", memRdValid, 0);
    for (int i = 0; i < rspGap; i++) begin
      check(!rspValid, "R4 no early response", rspValid, 0);
      check(!reqReady, "R10 still busy", reqReady, 0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    memRspValid = 1'b1; memRspData = desc;
    rspDue = cyc + 1;
    @(negedge clk);
    memRspValid = 1'b0; memRspData = 32'hDEAD_BEEF;
    @(negedge clk);
    check(reqReady && !rspValid, "R1 idle after response", {reqReady, rspValid}, 2'b10);
  endtask

  initial begin
    fork
      begin
        while (cyc < 100000 && !finished) @(posedge clk);
        if (!finished) begin
          finished = 1'b1;
          bad++; total++;
          $display("FAIL R4 watchdog act=%0d exp=done", cyc);
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1 && memRdValid == 0 && rspValid == 0, "R1 reset state",
          {reqReady, memRdValid, rspValid}, 3'b100);
    // R10: response strobe while idle must not start anything
    memRspValid = 1'b1; memRspData = 32'h1234_0002;
    @(negedge clk);
    memRspValid = 1'b0;
    @(negedge clk);
    check(!rspValid && !memRdValid && reqReady, "R10 idle ignores response",
          {reqReady, memRdValid, rspValid}, 3'b100);
    // R5 section, example table placement
    walk(32'h1230_0000, 32'h001A_BCDE, 1'b0, 32'hABC0_0C0E, 0, 0);
    // R6 supersection, last table entry
    walk(32'h8000_4000, 32'hFFF1_2345, 1'b0, 32'h5A04_0002, 2, 1);
    // R7 level-2 pointer
    walk(32'h0000_C000, 32'h7654_3210, 1'b1, 32'h3456_79E1, 1, 3);
    // R8 faults: fetch and data, plus reserved code
    walk(32'h4444_8000, 32'h0300_0010, 1'b1, 32'hFFFF_FFFC, 0, 2);
    walk(32'h4444_8000, 32'h0300_0010, 1'b0, 32'h0000_0000, 3, 0);
    walk(32'h2000_0000, 32'hC0DE_0004, 1'b0, 32'h1357_9BDF, 1, 1);
    walk(32'h2000_0000, 32'hC0DE_0004, 1'b1, 32'hFEDC_BA93, 2, 2);
    // R2 low base bits ignored; R5 section with attribute bits set
    walk(32'h1234_5FFF, 32'h9ABC_DEF0, 1'b1, 32'h800B_FFFE, 4, 0);
    // R6 supersection with attribute bits set
    walk(32'hFFFF_C000, 32'h0AAA_5555, 1'b1, 32'hC3FF_FFFE, 0, 4);
    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R4 every request answered", expQ.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule